// File: doc/BRIEF.md
# Priority Arbiter with Bandwidth Hold-Off

This block decides which of several request ports may write one command into a shared command queue in a given cycle. Each port has a programmable priority. The eligible requester with the highest priority value wins. When several eligible ports share that top priority, a round-robin pointer for that priority level picks between them. The grant is one-hot, and a queue push is asserted in the same cycle as the grant.

A bandwidth meter outside the block raises a per-port over-limit flag and pulses a report strobe at each statistics interval, which is typically ten cycles. The arbiter copies the flags into a per-port hold register only on that strobe. A held port takes no part in arbitration until a later strobe clears its hold.

Each port also has an overflow-enable bit. When it is set, a held port may still win, but only under two conditions. No port at the same priority level may be requesting without a hold. The queue must also hold fewer entries than a programmable threshold. The threshold leaves space in the queue, so a higher-priority port that starts requesting is not locked out by an over-budget port.

Top module: `bw_holdoff_arb`

## Requirements
- R1: While `rst_n` is low, `grant` and `push` are 0. Reset clears every port's hold, so before the first report strobe a requesting port is granted whatever its `over` flag shows.
- R2: A port is granted only while its `req` bit is 1. Among the eligible requesters, the one with the largest priority value wins. Port i's priority is `prio[2i+1:2i]`.
- R3: Ties inside one priority level are broken round-robin. After port p wins at a level, the next search at that level starts at port p+1 and wraps from 3 to 0. Reset places every level's pointer so that the search starts at port 0. Each level keeps its own pointer.
- R4: `grant` has at most one bit set. `push` is 1 exactly when `grant` is non-zero. No grant is issued while `q_count` >= 8, which is a full queue.
- R5: A port's hold is loaded from its `over` bit only at the clock edge where `report` is 1, and it takes effect from the next cycle. Between strobes, changes on `over` have no effect. A held port stays held even if it stops requesting.
- R6: A held port whose `ovf_en` bit is 0 is never granted. Lower-priority or same-level requesters that are not held can win in its place.
- R7: A held port with `ovf_en` = 1 becomes eligible only when `q_count` < `q_thresh` and no port without a hold at the same priority level is requesting. Requesters at other levels do not block the override.
- R8: When no port is eligible, `grant` and `push` stay 0 and no round-robin pointer moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-port request lines |
| prio | input | 8 | Per-port priority, 2 bits per port, port 0 in the low bits |
| over | input | 4 | Over-limit flags from the bandwidth meter |
| report | input | 1 | Statistics report strobe; loads the hold register |
| q_count | input | 4 | Current command queue occupancy |
| q_thresh | input | 4 | Occupancy below which an override is allowed |
| ovf_en | input | 4 | Per-port overflow-enable bits |
| grant | output | 4 | One-hot grant, same cycle as the request |
| push | output | 1 | Queue push, one cycle per grant |

## Verification
The assertions check several properties on every cycle:
- the grant is one-hot or zero and only goes to a requester;
- there is no push into a full queue;
- the hold register changes only on a strobe, and then copies the flags;
- a held port never wins without its overflow bit, or while the queue is at or above the threshold.

Some behaviours only the bench's scenarios can show, because each needs a known sequence of earlier grants or strobes. These are the choice of the highest priority, the round-robin order and its wrap within each level, and the independence of the per-level pointers. They also include the unmoved pointer after an idle or full-queue cycle, the one-cycle delay before a hold takes effect, and the blocking of an override by a same-level competitor without a hold.

// File: rtl/bw_holdoff_arb.sv
module bw_holdoff_arb #(
  parameter int NPORT  = 4,
  parameter int PW     = 2,
  parameter int QW     = 4,
  parameter int QDEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req,
  input  logic [NPORT*PW-1:0] prio,
  input  logic [NPORT-1:0]    over,
  input  logic                report,
  input  logic [QW-1:0]       q_count,
  input  logic [QW-1:0]       q_thresh,
  input  logic [NPORT-1:0]    ovf_en,
  output logic [NPORT-1:0]    grant,
  output logic                push
);
  localparam int NLEV = 1 << PW;
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [QW-1:0] FULL = QW'(QDEPTH);

  logic [NPORT-1:0] held, normal, ovr_ok, elig;
  logic [PW-1:0]    pr [NPORT];
  logic [IW-1:0]    ptr [NLEV];
  logic [PW-1:0]    top;
  logic             any, room, below;
  logic [IW-1:0]    win;

  for (genvar g = 0; g < NPORT; g++) begin : g_pr
    assign pr[g] = prio[g*PW +: PW];
  end

  assign room   = q_count < FULL;
  assign below  = q_count < q_thresh;
  assign normal = req & ~held;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < NPORT; j++)
        if (j != i && normal[j] && pr[j] == pr[i]) blk = 1'b1;
      ovr_ok[i] = req[i] & held[i] & ovf_en[i] & below & ~blk;
    end
  end

  assign elig = normal | ovr_ok;

  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = 0; i < NPORT; i++)
      if (elig[i] && (!any || pr[i] > top)) begin
        top = pr[i];
        any = 1'b1;
      end
  end

  always_comb begin
    logic found;
    logic [IW-1:0] idx;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < NPORT; k++) begin
      idx = ptr[top] + IW'(1) + IW'(k);
      if (!found && elig[idx] && pr[idx] == top) begin
        found = 1'b1;
        win   = idx;
      end
    end
  end

  assign grant = (rst_n && any && room) ? ({{(NPORT-1){1'b0}}, 1'b1} << win) : '0;
  assign push  = |grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      for (int l = 0; l < NLEV; l++) ptr[l] <= IW'(NPORT-1);
    end else begin
      if (report) held <= over;
      if (push) ptr[top] <= win;
    end
  end
endmodule

module bw_holdoff_arb_chk #(
  parameter int NPORT  = 4,
  parameter int QW     = 4,
  parameter int QDEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] req,
  input logic [NPORT-1:0] over,
  input logic             report,
  input logic [QW-1:0]    q_count,
  input logic [QW-1:0]    q_thresh,
  input logic [NPORT-1:0] ovf_en,
  input logic [NPORT-1:0] held,
  input logic [NPORT-1:0] grant,
  input logic             push
);
  localparam logic [QW-1:0] FULL = QW'(QDEPTH);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  p_push_r4:   assert property (@(posedge clk) disable iff (!rst_n) push == (grant != '0));
  p_full_r4:   assert property (@(posedge clk) disable iff (!rst_n) (q_count >= FULL) |-> !push);
  p_req_r2:    assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req) == '0);
  p_idle_r8:   assert property (@(posedge clk) disable iff (!rst_n) (req == '0) |-> (grant == '0));
  p_stable_r5: assert property (@(posedge clk) disable iff (!rst_n) !report |=> $stable(held));
  p_load_r5:   assert property (@(posedge clk) disable iff (!rst_n) report |=> held == $past(over));
  p_noovf_r6:  assert property (@(posedge clk) disable iff (!rst_n) (grant & held & ~ovf_en) == '0);
  p_thresh_r7: assert property (@(posedge clk) disable iff (!rst_n) (|(grant & held)) |-> (q_count < q_thresh));
endmodule

bind bw_holdoff_arb bw_holdoff_arb_chk #(.NPORT(NPORT), .QW(QW), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .over(over), .report(report),
  .q_count(q_count), .q_thresh(q_thresh), .ovf_en(ovf_en), .held(held),
  .grant(grant), .push(push)
);

// File: tb/sim_bw_holdoff_arb.sv
`timescale 1ns/1ps
module sim_bw_holdoff_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0, over = '0, ovf_en = '0;
  logic [7:0] prio = '0;
  logic       report = 1'b0;
  logic [3:0] q_count = '0, q_thresh = 4'd4;
  logic [3:0] grant;
  logic       push;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] g; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  bw_holdoff_arb u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .over(over),
    .report(report), .q_count(q_count), .q_thresh(q_thresh),
    .ovf_en(ovf_en), .grant(grant), .push(push)
  );

  task automatic drive(input logic [3:0] r, input logic [7:0] p, input logic [3:0] ov,
                       input logic rp, input logic [3:0] qc, input logic [3:0] oe,
                       input logic [3:0] eg, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; prio = p; over = ov; report = rp; q_count = qc; ovf_en = oe;
    e.g = eg; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        tests++;
        if (grant !== e.g || push !== (e.g != 4'b0)) begin
          fails++;
          $display("FAIL %s: grant=%b push=%b expected grant=%b push=%b",
                   e.tag, grant, push, e.g, (e.g != 4'b0));
        end
      end
    end
  end

  initial begin
    drive(4'hF, 8'h00, 4'h0, 0, 0, 4'h0, 4'b0000, "R1 no grant in reset");
    #5 rst_n = 1'b1;
    drive(4'b0001, 8'h00, 4'b0001, 0, 0, 4'h0, 4'b0001, "R1 hold cleared by reset");
    drive(4'hF, 8'h00, 4'h0, 0, 0, 4'h0, 4'b0010, "R3 rr step 1");
    drive(4'hF, 8'h00, 4'h0, 0, 0, 4'h0, 4'b0100, "R3 rr step 2");
    drive(4'hF, 8'h00, 4'h0, 0, 0, 4'h0, 4'b1000, "R3 rr step 3");
    drive(4'hF, 8'h00, 4'h0, 0, 0, 4'h0, 4'b0001, "R3 rr wrap");
    drive(4'hF, 8'h30, 4'h0, 0, 0, 4'h0, 4'b0100, "R2 top priority wins");
    drive(4'b1011, 8'h89, 4'h0, 0, 0, 4'h0, 4'b0010, "R2 level2 first");
    drive(4'b1011, 8'h89, 4'h0, 0, 0, 4'h0, 4'b1000, "R3 level2 rotate");
    drive(4'hF, 8'h00, 4'h0, 0, 0, 4'h0, 4'b0010, "R3 level0 pointer kept");
    drive(4'hF, 8'h00, 4'h0, 0, 4'd8, 4'h0, 4'b0000, "R4 full queue");
    drive(4'hF, 8'h00, 4'h0, 0, 4'd7, 4'h0, 4'b0100, "R4 one slot left");
    drive(4'h0, 8'h00, 4'h0, 0, 0, 4'h0, 4'b0000, "R8 idle");
    drive(4'hF, 8'h00, 4'h0, 0, 0, 4'h0, 4'b1000, "R8 pointer unmoved");
    drive(4'b0010, 8'h00, 4'b0010, 1, 0, 4'h0, 4'b0010, "R5 strobe cycle not yet held");
    drive(4'b0010, 8'h00, 4'b0000, 0, 0, 4'h0, 4'b0000, "R6 held no overflow");
    drive(4'b0011, 8'h00, 4'b0000, 0, 0, 4'h0, 4'b0001, "R6 other port wins");
    drive(4'b0000, 8'h00, 4'b0000, 0, 0, 4'h0, 4'b0000, "R5 idle while held");
    drive(4'b0010, 8'h00, 4'b0000, 0, 0, 4'b0010, 4'b0010, "R7 override granted");
    drive(4'b0011, 8'h00, 4'b0000, 0, 0, 4'b0010, 4'b0001, "R7 same-level competitor blocks");
    drive(4'b0010, 8'h00, 4'b0000, 0, 4'd4, 4'b0010, 4'b0000, "R7 queue at threshold");
    drive(4'b0010, 8'h00, 4'b0000, 0, 4'd3, 4'b0010, 4'b0010, "R7 queue below threshold");
    drive(4'b0011, 8'h01, 4'b0000, 0, 0, 4'b0010, 4'b0001, "R2 higher normal beats override");
    drive(4'b0011, 8'h08, 4'b0000, 0, 0, 4'b0010, 4'b0010, "R7 other level does not block");
    drive(4'b0010, 8'h08, 4'b0000, 1, 0, 4'h0, 4'b0000, "R5 still held on clearing strobe");
    drive(4'b0010, 8'h08, 4'b0000, 0, 0, 4'h0, 4'b0010, "R5 released after strobe");
    drive(4'hF, 8'h00, 4'hF, 0, 0, 4'h0, 4'b0100, "R5 over ignored between strobes");
    drive(4'hF, 8'h00, 4'b1000, 1, 0, 4'h0, 4'b1000, "R5 grant in strobe cycle");
    drive(4'b1000, 8'h00, 4'b0000, 0, 0, 4'h0, 4'b0000, "R5 held after strobe");
    @(negedge clk);
    @(negedge clk);
    req = '0;
    #4;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule